// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block carries out one management transaction at a time with an external PHY over the two-wire management bus. Software hands it a single 32-bit management word that already holds the whole frame: start code, opcode, PHY address, register address, turnaround code and 16 data bits. The engine first sends a preamble of 32 ones. It then sends the word most significant bit first, on a management clock derived from the system clock.

For a read, the engine releases the data line from the turnaround onward and collects the 16 bits the PHY returns. When the frame ends, those bits replace the low half of the stored word, so software reads the result from the same word it wrote. An enable input gates the start of new frames. An idle output shows whether a frame is in flight. A select input picks one of six clock ratios and is captured when each frame starts.

Word layout, where the serial order depends on it: bits 31:30 start code (01), bits 29:28 opcode (01 write, 10 read), bits 27:23 PHY address, bits 22:18 register address, bits 17:16 turnaround (10), bits 15:0 data.

Top module: `mdio_engine`

## Requirements
- R1: An accepted frame consists of exactly 64 MDC cycles. The first 32 carry preamble bits, and MDC cycles 32 to 63 carry mgmtWord bits 31 down to 0, in that order. mdioOut is taken on the rising edge of MDC.
- R2: During all 32 preamble cycles mdioOut is 1 and mdioOe is 1.
- R3: The MDC period is 8, 16, 32, 48, 64 or 96 system clocks for divSel 0, 1, 2, 3, 4 and 5 respectively. divSel 6 and 7 also give 96. divSel is captured when the frame is accepted.
- R4: For opcode 10 (word bits 29:28), mdioOe is 0 from frame bit 14 (the turnaround) to the end of the frame. mdioIn is sampled on MDC rising edges of frame bits 16 to 31, MSB first. At completion mgmtWord[15:0] takes the sampled value and mgmtWord[31:16] is unchanged. The data field does not change before completion.
- R5: For any opcode other than 10, mdioOe is 1 for the whole frame and mgmtWord is unchanged at completion.
- R6: mdioOut changes only in the system cycle in which MDC falls.
- R7: A wrEn pulse while enable is 0 is ignored. idle stays 1, no MDC edge appears and mgmtWord keeps its value.
- R8: idle goes to 0 in the cycle after an accepted wrEn and returns to 1 when the frame ends. While idle is 1, mdc is 0 and mdioOe is 0.
- R9: A wrEn pulse while a frame is in progress is ignored. The frame bits and the final mgmtWord are those of the frame already running.
- R10: After reset, idle is 1, mdc is 0, mdioOe is 0, mdioOut is 1 and mgmtWord is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Port enable; frames start only while high |
| divSel | input | 3 | MDC ratio select, captured at frame start |
| wrEn | input | 1 | One-cycle strobe that loads wrWord and starts a frame |
| wrWord | input | 32 | Management word to send |
| mgmtWord | output | 32 | Stored management word, with read data after a read |
| idle | output | 1 | High when no frame is being shifted |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Management data driven value |
| mdioOe | output | 1 | Management data output enable |
| mdioIn | input | 1 | Management data received value |

## Verification
The assertions assume that mdioIn is changed by the PHY well away from MDC rising edges. They also assume that the stored word's opcode field stays fixed through a frame, which holds because the engine ignores writes during a frame. The bench's PHY model changes mdioIn only on MDC falling edges, half an MDC period before each sample. Stimulus drives wrEn, enable and divSel only at system clock falling edges, including a write issued mid-frame and a write issued while the port is disabled.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  parameter int PRE_BITS   = 32;
  parameter int FRAME_BITS = 32;
  parameter int DATA_BITS  = 16;
  parameter int TA_POS     = 14;
  parameter int TOTAL_BITS = PRE_BITS + FRAME_BITS;
  parameter int CNT_W      = $clog2(TOTAL_BITS);
  parameter int HALF_W     = 6;

  typedef struct packed {
    logic             load;
    logic             present;
    logic             sample;
    logic             commit;
    logic [CNT_W-1:0] bitIdx;
  } ctrlStrb_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       wrEn,
  input  logic [2:0] divSel,
  input  logic       isRead,
  output ctrlStrb_t  strb,
  output logic       idle,
  output logic       mdc
);
  localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(TOTAL_BITS - 1);
  localparam logic [CNT_W-1:0] FIRST_RX  = CNT_W'(PRE_BITS + DATA_BITS);

  logic              busy;
  logic [HALF_W-1:0] halfReg;
  logic [HALF_W-1:0] divCnt;
  logic              mdcR;
  logic [CNT_W-1:0]  bitCnt;
  logic              tickEnd;
  logic              riseTick;
  logic              fallTick;
  logic              lastFall;

  function automatic logic [HALF_W-1:0] halfOf(input logic [2:0] sel);
    case (sel)
      3'd0:    halfOf = HALF_W'(4);
      3'd1:    halfOf = HALF_W'(8);
      3'd2:    halfOf = HALF_W'(16);
      3'd3:    halfOf = HALF_W'(24);
      3'd4:    halfOf = HALF_W'(32);
      default: halfOf = HALF_W'(48);
    endcase
  endfunction

  always_comb begin
    tickEnd  = busy && (divCnt == halfReg - HALF_W'(1));
    riseTick = tickEnd && !mdcR;
    fallTick = tickEnd && mdcR;
    lastFall = fallTick && (bitCnt == LAST_IDX);
    strb.load    = !busy && wrEn && enable;
    strb.present = fallTick && !lastFall;
    strb.sample  = riseTick && isRead && (bitCnt >= FIRST_RX);
    strb.commit  = lastFall;
    strb.bitIdx  = bitCnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      halfReg <= HALF_W'(4);
      divCnt  <= '0;
      mdcR    <= 1'b0;
      bitCnt  <= '0;
    end else if (strb.load) begin
      busy    <= 1'b1;
      halfReg <= halfOf(divSel);
      divCnt  <= '0;
      mdcR    <= 1'b0;
      bitCnt  <= '0;
    end else if (busy) begin
      if (tickEnd) begin
        divCnt <= '0;
        mdcR   <= !mdcR;
        if (lastFall) busy <= 1'b0;
        else if (fallTick) bitCnt <= bitCnt + CNT_W'(1);
      end else begin
        divCnt <= divCnt + HALF_W'(1);
      end
    end
  end

  assign idle = !busy;
  assign mdc  = mdcR;
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ctrlStrb_t   strb,
  input  logic [31:0] wrWord,
  input  logic        mdioIn,
  output logic [31:0] mgmtWord,
  output logic        isRead,
  output logic        mdioOut,
  output logic        mdioOe
);
  logic [31:0]          wordR;
  logic [DATA_BITS-1:0] capR;
  logic                 outR;
  logic                 oeR;
  logic                 inPre;
  logic [CNT_W-1:0]     frameIdx;
  logic [4:0]           k;
  logic                 relOe;
  logic                 nextOut;

  always_comb begin
    isRead   = (wordR[29:28] == 2'b10);
    inPre    = (strb.bitIdx < CNT_W'(PRE_BITS));
    frameIdx = strb.bitIdx - CNT_W'(PRE_BITS);
    k        = frameIdx[4:0];
    relOe    = isRead && !inPre && (k >= 5'(TA_POS));
    nextOut  = (inPre || relOe) ? 1'b1 : wordR[5'd31 - k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wordR <= '0;
      capR  <= '0;
      outR  <= 1'b1;
      oeR   <= 1'b0;
    end else begin
      if (strb.load) begin
        wordR <= wrWord;
        capR  <= '0;
        outR  <= 1'b1;
        oeR   <= 1'b1;
      end
      if (strb.present) begin
        outR <= nextOut;
        oeR  <= !relOe;
      end
      if (strb.sample) capR <= {capR[DATA_BITS-2:0], mdioIn};
      if (strb.commit) begin
        if (isRead) wordR[DATA_BITS-1:0] <= capR;
        outR <= 1'b1;
        oeR  <= 1'b0;
      end
    end
  end

  assign mgmtWord = wordR;
  assign mdioOut  = outR;
  assign mdioOe   = oeR;
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [2:0]  divSel,
  input  logic        wrEn,
  input  logic [31:0] wrWord,
  output logic [31:0] mgmtWord,
  output logic        idle,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  ctrlStrb_t strb;
  logic      isRead;

  mdio_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wrEn(wrEn),
    .divSel(divSel), .isRead(isRead), .strb(strb), .idle(idle), .mdc(mdc)
  );

  mdio_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrWord(wrWord), .mdioIn(mdioIn),
    .mgmtWord(mgmtWord), .isRead(isRead), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );
endmodule

// File: rtl/mdio_engine_chk.sv
module mdio_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        wrEn,
  input logic [31:0] mgmtWord,
  input logic        idle,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe
);
  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdioOut) |-> $fell(mdc)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!mdc && !mdioOe)); // R8
  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && enable && wrEn) |=> !idle); // R8
  AST_GATED_START: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !enable) |=> idle); // R7
  AST_HEADER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(mgmtWord[31:16])); // R9
  AST_DATA_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> ($stable(mgmtWord[15:0]) || idle)); // R4
  AST_READ_ONLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !mdioOe) |-> (mgmtWord[29:28] == 2'b10)); // R5
endmodule

bind mdio_engine mdio_engine_chk u_chk (.*);

// File: tb/mdio_engine_tb.sv
module mdio_engine_tb;
  localparam int PRE   = 32;
  localparam int TOTAL = 64;
  localparam int ARR   = 8192;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic [2:0]  divSel = 3'd0;
  logic        wrEn = 1'b0;
  logic [31:0] wrWord = '0;
  logic [31:0] mgmtWord;
  logic        idle, mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int riseIdx = 0;
  int base = 0;
  int badEdge = 0;
  logic [15:0] phyData = '0;
  logic recOut [ARR];
  logic recOe  [ARR];
  int   riseCyc [ARR];
  logic prevOut = 1'b1;
  logic prevMdc = 1'b0;
  int seedDummy;

  mdio_engine u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .divSel(divSel), .wrEn(wrEn),
    .wrWord(wrWord), .mgmtWord(mgmtWord), .idle(idle), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(posedge mdc) begin
    if (riseIdx < ARR) begin
      recOut[riseIdx]  = mdioOut;
      recOe[riseIdx]   = mdioOe;
      riseCyc[riseIdx] = cyc;
    end
    riseIdx++;
  end

  always @(negedge mdc) begin
    int rel;
    rel = riseIdx - base;
    if (rel >= PRE + 16 && rel < TOTAL) mdioIn = phyData[15 - (rel - PRE - 16)];
    else mdioIn = 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && (mdioOut != prevOut) && !(prevMdc && !mdc)) badEdge++;
    prevOut = mdioOut;
    prevMdc = mdc;
  end

  task automatic check(input string req, input logic ok,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ratioOf(input logic [2:0] sel);
    case (sel)
      3'd0: return 8;
      3'd1: return 16;
      3'd2: return 32;
      3'd3: return 48;
      3'd4: return 64;
      default: return 96;
    endcase
  endfunction

  task automatic runFrame(input logic [31:0] w, input logic [2:0] sel,
                          input logic [15:0] pd, input logic poke);
    int waitCnt, nRise, badPre, badBits, badPer;
    logic rd;
    logic [31:0] expWord;
    rd = (w[29:28] == 2'b10);
    phyData = pd;
    base = riseIdx;
    @(negedge clk);
    divSel = sel; wrWord = w; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    divSel = ~sel;
    check("R8 busy after load", idle == 1'b0, {31'd0, idle}, 32'd0);
    if (poke) begin
      repeat (100) @(negedge clk);
      wrWord = ~w; wrEn = 1'b1;
      @(negedge clk);
      wrEn = 1'b0;
    end
    waitCnt = 0;
    while (!idle && waitCnt < 10000) begin
      @(negedge clk);
      waitCnt++;
    end
    nRise = riseIdx - base;
    check("R1 mdc cycle count", nRise == TOTAL, nRise, TOTAL);
    check("R8 quiet when idle", idle && !mdc && !mdioOe,
          {29'd0, idle, mdc, mdioOe}, 32'd4);
    badPre = 0; badBits = 0; badPer = 0;
    if (nRise == TOTAL) begin
      for (int i = 0; i < PRE; i++)
        if (recOut[base+i] !== 1'b1 || recOe[base+i] !== 1'b1) badPre++;
      for (int q = 0; q < 32; q++) begin
        if (rd && q >= 14) begin
          if (recOe[base+PRE+q] !== 1'b0) badBits++;
        end else begin
          if (recOe[base+PRE+q] !== 1'b1 || recOut[base+PRE+q] !== w[31-q]) badBits++;
        end
      end
      for (int i = 1; i < TOTAL; i++)
        if (riseCyc[base+i] - riseCyc[base+i-1] != ratioOf(sel)) badPer++;
    end
    check("R2 preamble ones driven", badPre == 0, badPre, 0);
    if (rd) check("R4 read frame bits and release", badBits == 0, badBits, 0);
    else check("R5 write frame bits driven", badBits == 0, badBits, 0);
    check("R3 mdc period", badPer == 0, badPer, 0);
    expWord = rd ? {w[31:16], pd} : w;
    if (poke) check("R9 word after busy write", mgmtWord == expWord, mgmtWord, expWord);
    else if (rd) check("R4 read data returned", mgmtWord == expWord, mgmtWord, expWord);
    else check("R5 word kept", mgmtWord == expWord, mgmtWord, expWord);
  endtask

  function automatic logic [31:0] mkWord(input logic [1:0] op, input logic [4:0] phy,
                                         input logic [4:0] rg, input logic [15:0] d);
    return {2'b01, op, phy, rg, 2'b10, d};
  endfunction

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] held;
    int b0;
    seedDummy = $urandom(32'h5eed_0042);
    repeat (4) @(negedge clk);
    check("R10 reset state", idle && !mdc && !mdioOe && mdioOut && mgmtWord == 0,
          {mgmtWord[27:0], idle, mdc, mdioOe, mdioOut}, 32'h9);
    rst_n = 1'b1;
    @(negedge clk);

    runFrame(mkWord(2'b01, 5'd3, 5'd4, 16'hA5C3), 3'd0, 16'h0, 1'b0);
    runFrame(mkWord(2'b10, 5'd31, 5'd1, 16'h0000), 3'd5, 16'hB00F, 1'b0);
    runFrame(mkWord(2'b10, 5'd0, 5'd31, 16'hFFFF), 3'd3, 16'h0001, 1'b0);
    runFrame(mkWord(2'b01, 5'd17, 5'd9, 16'h8001), 3'd7, 16'h0, 1'b0);
    runFrame(mkWord(2'b00, 5'd5, 5'd5, 16'h1234), 3'd1, 16'h0, 1'b0);
    runFrame(mkWord(2'b11, 5'd6, 5'd2, 16'hFEDC), 3'd2, 16'h0, 1'b0);
    runFrame(mkWord(2'b10, 5'd2, 5'd3, 16'h0), 3'd4, 16'h8000, 1'b0);
    runFrame(mkWord(2'b01, 5'd9, 5'd8, 16'h5555), 3'd0, 16'h0, 1'b1);
    runFrame(mkWord(2'b10, 5'd9, 5'd8, 16'h0), 3'd1, 16'h3C96, 1'b1);

    held = mgmtWord;
    enable = 1'b0;
    b0 = riseIdx;
    @(negedge clk);
    wrWord = mkWord(2'b01, 5'd1, 5'd1, 16'hDEAD); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    repeat (40) @(negedge clk);
    check("R7 disabled write ignored", idle && riseIdx == b0 && mgmtWord == held,
          mgmtWord, held);
    enable = 1'b1;

    for (int n = 0; n < 12; n++) begin
      logic [1:0] op;
      op = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
      runFrame(mkWord(op, 5'($urandom), 5'($urandom), 16'($urandom)),
               3'($urandom % 4), 16'($urandom), 1'b0);
    end

    check("R6 output moves only on mdc fall", badEdge == 0, badEdge, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule